// File: doc/BRIEF.md
# Bridge Fault Flag and Sense-Hold Controller

This block is the digital supervisor that sits between the analog comparators of a full-bridge gate driver and the pin that reports trouble to the host. It watches an overcurrent comparator and one drain-source voltage comparator per bridge switch. It turns these into an active-low status flag and a latched bridge-disable, and it drives the two controls of the sense-voltage sample-and-hold (hold and force-to-zero).

Overcurrent indication is stretched by a retriggerable hold counter, so short chopping bursts show up as a steady low flag. A drain-source trip latches the bridge off at once and keeps the flag low until a standby entry or an undervoltage event clears it. Each switch's comparator is masked while the switch is off and during a blanking window after it turns on. For a commanded turn-on the window ends when an external RC blank timer reports expiry. For a synchronous-rectification turn-on it has a fixed length. The sample-and-hold holds during the mixed-decay off-time and during slow decay with the enable input low. It is forced to zero after the enable input has been low for a timeout, and for as long as a drain-source fault is latched.

Top module: `bridge_fault_flag`

## Requirements
- R1: A cycle with `oc_trip` high at cycle c drives `flag_n` low in cycles c+1 through c+HOLD_CYC+1. With no further trip, `flag_n` returns high in cycle c+HOLD_CYC+2.
- R2: Every new `oc_trip` cycle restarts the hold interval, so `flag_n` stays low until HOLD_CYC+1 cycles after the last trip.
- R3: When an armed switch reports `vds_trip`, `vds_latched` goes high and `flag_n` goes low in the next cycle. Both stay that way while the latch is held.
- R4: The latch clears in the cycle after `standby` or `uv_fault` is high, and only then. A clear request takes priority over a trip seen in the same cycle.
- R5: `vds_trip` of a switch whose `sw_on` is low has no effect on `vds_latched`.
- R6: After a commanded turn-on (`sr_offtime` low in the first cycle `sw_on` is high), the switch is masked until `rc_blank_done` is seen high in a later cycle. It is armed from the cycle after that. `rc_blank_done` in the turn-on cycle itself is ignored.
- R7: After a turn-on with `sr_offtime` high in its first on cycle, the switch is masked for a fixed window and armed from SR_BLANK_CYC+1 cycles after its first on cycle, whatever `rc_blank_done` does.
- R8: `chop_phase` encodes 0 = drive, 1 = mixed-decay off-time, 2 = slow decay, 3 = fast decay. `sh_hold` is high in the next cycle for phase 1, and for phase 2 with `enable` low. It is low for phases 0 and 3.
- R9: `sh_zero` goes high ZERO_DELAY_CYC cycles after the first cycle with `enable` low, provided `enable` stays low. It drops in the cycle after `enable` returns high, unless a fault is latched.
- R10: `sh_zero` is high whenever `vds_latched` is high, and `sh_hold` is low whenever `sh_zero` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip | input | 1 | Overcurrent comparator output |
| vds_trip | input | NUM_SW | Drain-source comparator output per switch |
| sw_on | input | NUM_SW | Gate command per switch, high when on |
| rc_blank_done | input | NUM_SW | RC blank timer expired, per switch |
| sr_offtime | input | 1 | Bridge is in a synchronous-rectification off-time |
| standby | input | 1 | Standby entry, clears the fault latch |
| uv_fault | input | 1 | Undervoltage event, clears the fault latch |
| enable | input | 1 | External enable level |
| chop_phase | input | 2 | Current decay phase, encoded as in R8 |
| flag_n | output | 1 | Registered active-low status flag |
| vds_latched | output | 1 | Latched bridge-disable from a drain-source fault |
| sh_hold | output | 1 | Sample-and-hold hold command |
| sh_zero | output | 1 | Sample-and-hold force-to-zero command |

## Verification
Two pairs of functions can fall in the same cycle. The bench provokes both pairs on purpose and compares every output each cycle against a behavioural model. In the first pair, an overcurrent trip and a drain-source latch drive the flag together. When the hold interval runs out, the flag must stay low because of the latch alone, and it must rise only after a standby clear. In the second pair, the enable-low timeout expires while the mixed-decay phase is asking for a hold. In that cycle the zero command must win and the hold must drop at the same edge. A clear request arriving together with a live trip is also driven, to confirm that the clear takes priority.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

   typedef enum logic [1:0] {
      PH_DRIVE     = 2'd0,
      PH_MIXED_OFF = 2'd1,
      PH_SLOW      = 2'd2,
      PH_FAST      = 2'd3
   } chop_phase_e;

endpackage

// File: rtl/ffl_oc_stretch.sv
module ffl_oc_stretch #(
   parameter int HOLD_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_trip,
   output logic oc_active
);
   localparam int CW = $clog2(HOLD_CYC + 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("ffl_oc_stretch: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   // A new trip reloads the counter; otherwise it runs down to zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (oc_trip) begin
         cnt_q <= CW'(HOLD_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign oc_active = oc_trip | (cnt_q != '0);

endmodule

// File: rtl/ffl_vds_monitor.sv
module ffl_vds_monitor #(
   parameter int NUM_SW         = 4,
   parameter int SR_BLANK_CYC   = 200,
   parameter bit SR_FIXED_BLANK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SW-1:0] vds_trip,
   input  logic [NUM_SW-1:0] sw_on,
   input  logic [NUM_SW-1:0] rc_blank_done,
   input  logic              sr_offtime,
   input  logic              clear_req,
   output logic              lat_q,
   output logic              lat_next
);
   localparam int SCW = $clog2(SR_BLANK_CYC + 1);

   if (NUM_SW < 1) begin : g_bad_num
      $error("ffl_vds_monitor: NUM_SW must be at least 1");
   end
   if (SR_BLANK_CYC < 1) begin : g_bad_sr
      $error("ffl_vds_monitor: SR_BLANK_CYC must be at least 1");
   end

   logic sr_sel;
   logic [NUM_SW-1:0] armed;
   logic det;

   // Variant choice: fixed short blanking for rectification turn-ons,
   // or RC blanking for every turn-on.
   if (SR_FIXED_BLANK) begin : g_sr_fixed
      assign sr_sel = sr_offtime;
   end else begin : g_sr_rc
      assign sr_sel = 1'b0;
   end

   for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
      logic           prev_on;
      logic           in_blank;
      logic           use_sr;
      logic [SCW-1:0] sr_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_on  <= 1'b0;
            in_blank <= 1'b0;
            use_sr   <= 1'b0;
            sr_cnt   <= '0;
         end else if (!sw_on[i]) begin
            prev_on  <= 1'b0;
            in_blank <= 1'b0;
            sr_cnt   <= '0;
         end else begin
            prev_on <= 1'b1;
            if (!prev_on) begin
               in_blank <= 1'b1;
               use_sr   <= sr_sel;
               sr_cnt   <= SCW'(SR_BLANK_CYC - 1);
            end else if (in_blank) begin
               if (use_sr) begin
                  if (sr_cnt == '0) begin
                     in_blank <= 1'b0;
                  end else begin
                     sr_cnt <= sr_cnt - SCW'(1);
                  end
               end else if (rc_blank_done[i]) begin
                  in_blank <= 1'b0;
               end
            end
         end
      end

      assign armed[i] = sw_on[i] & prev_on & ~in_blank;
   end

   assign det      = |(armed & vds_trip);
   assign lat_next = clear_req ? 1'b0 : (lat_q | det);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= 1'b0;
      end else begin
         lat_q <= lat_next;
      end
   end

endmodule

// File: rtl/ffl_sh_ctrl.sv
module ffl_sh_ctrl
   import ffl_pkg::*;
#(
   parameter int ZERO_DELAY_CYC = 60000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  chop_phase_e phase,
   input  logic        lat_next,
   output logic        hold_q,
   output logic        zero_q
);
   localparam int ZW = $clog2(ZERO_DELAY_CYC + 1);

   if (ZERO_DELAY_CYC < 1) begin : g_bad_zero
      $error("ffl_sh_ctrl: ZERO_DELAY_CYC must be at least 1");
   end

   logic [ZW-1:0] en_q;
   logic [ZW-1:0] en_next;
   logic          zero_next;
   logic          hold_want;
   logic          hold_next;

   always_comb begin
      en_next = en_q;
      if (enable) begin
         en_next = '0;
      end else if (en_q != ZW'(ZERO_DELAY_CYC)) begin
         en_next = en_q + ZW'(1);
      end
   end

   always_comb begin
      unique case (phase)
         PH_MIXED_OFF: hold_want = 1'b1;
         PH_SLOW:      hold_want = ~enable;
         PH_FAST:      hold_want = 1'b0;
         default:      hold_want = 1'b0;
      endcase
   end

   assign zero_next = lat_next | (en_next == ZW'(ZERO_DELAY_CYC));
   assign hold_next = hold_want & ~zero_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         hold_q <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         en_q   <= en_next;
         hold_q <= hold_next;
         zero_q <= zero_next;
      end
   end

endmodule

// File: rtl/bridge_fault_flag.sv
module bridge_fault_flag
   import ffl_pkg::*;
#(
   parameter int NUM_SW         = 4,
   parameter int HOLD_CYC       = 100000,
   parameter int SR_BLANK_CYC   = 200,
   parameter int ZERO_DELAY_CYC = 60000,
   parameter bit SR_FIXED_BLANK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oc_trip,
   input  logic [NUM_SW-1:0] vds_trip,
   input  logic [NUM_SW-1:0] sw_on,
   input  logic [NUM_SW-1:0] rc_blank_done,
   input  logic              sr_offtime,
   input  logic              standby,
   input  logic              uv_fault,
   input  logic              enable,
   input  logic [1:0]        chop_phase,
   output logic              flag_n,
   output logic              vds_latched,
   output logic              sh_hold,
   output logic              sh_zero
);
   logic        oc_active;
   logic        lat_next;
   logic        clear_req;
   chop_phase_e phase;

   assign clear_req = standby | uv_fault;
   assign phase     = chop_phase_e'(chop_phase);

   ffl_oc_stretch #(
      .HOLD_CYC(HOLD_CYC)
   ) u_oc (
      .clk      (clk),
      .rst_n    (rst_n),
      .oc_trip  (oc_trip),
      .oc_active(oc_active)
   );

   ffl_vds_monitor #(
      .NUM_SW        (NUM_SW),
      .SR_BLANK_CYC  (SR_BLANK_CYC),
      .SR_FIXED_BLANK(SR_FIXED_BLANK)
   ) u_vds (
      .clk          (clk),
      .rst_n        (rst_n),
      .vds_trip     (vds_trip),
      .sw_on        (sw_on),
      .rc_blank_done(rc_blank_done),
      .sr_offtime   (sr_offtime),
      .clear_req    (clear_req),
      .lat_q        (vds_latched),
      .lat_next     (lat_next)
   );

   ffl_sh_ctrl #(
      .ZERO_DELAY_CYC(ZERO_DELAY_CYC)
   ) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .phase   (phase),
      .lat_next(lat_next),
      .hold_q  (sh_hold),
      .zero_q  (sh_zero)
   );

   // Registered flag: one clean edge per change, no decode glitches.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_n <= 1'b1;
      end else begin
         flag_n <= ~(oc_active | lat_next);
      end
   end

endmodule

// File: rtl/ffl_checker.sv
module ffl_checker #(
   parameter int NUM_SW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              oc_trip,
   input logic [NUM_SW-1:0] sw_on,
   input logic              standby,
   input logic              uv_fault,
   input logic              enable,
   input logic [1:0]        chop_phase,
   input logic              flag_n,
   input logic              vds_latched,
   input logic              sh_hold,
   input logic              sh_zero
);

   p_flag_on_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip |=> !flag_n);

   p_release_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_n) |-> !$past(oc_trip));

   p_fault_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vds_latched) |-> !flag_n);

   p_latch_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vds_latched && !standby && !uv_fault) |=> vds_latched);

   p_latch_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (standby || uv_fault) |=> !vds_latched);

   p_off_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vds_latched && sw_on == '0) |=> !vds_latched);

   p_fast_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_phase == 2'd3) |=> !sh_hold);

   p_enable_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> (sh_zero == vds_latched));

   p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vds_latched |-> sh_zero);

   p_zero_over_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sh_zero |-> !sh_hold);

endmodule

bind bridge_fault_flag ffl_checker #(
   .NUM_SW(NUM_SW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .oc_trip    (oc_trip),
   .sw_on      (sw_on),
   .standby    (standby),
   .uv_fault   (uv_fault),
   .enable     (enable),
   .chop_phase (chop_phase),
   .flag_n     (flag_n),
   .vds_latched(vds_latched),
   .sh_hold    (sh_hold),
   .sh_zero    (sh_zero)
);

// File: tb/sim_bridge_fault_flag.sv
module sim_bridge_fault_flag;
   localparam int N     = 4;
   localparam int H     = 20;
   localparam int S     = 4;
   localparam int AZ    = 30;
   localparam int GUARD = 50000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         oc_trip = 1'b0;
   logic [N-1:0] vds_trip = '0;
   logic [N-1:0] sw_on = '0;
   logic [N-1:0] rc_blank_done = '0;
   logic         sr_offtime = 1'b0;
   logic         standby = 1'b0;
   logic         uv_fault = 1'b0;
   logic         enable = 1'b1;
   logic [1:0]   chop_phase = 2'd0;
   logic         flag_n;
   logic         vds_latched;
   logic         sh_hold;
   logic         sh_zero;

   always #2500 clk = ~clk;

   bridge_fault_flag #(
      .NUM_SW(N), .HOLD_CYC(H), .SR_BLANK_CYC(S), .ZERO_DELAY_CYC(AZ)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip), .vds_trip(vds_trip),
      .sw_on(sw_on), .rc_blank_done(rc_blank_done), .sr_offtime(sr_offtime),
      .standby(standby), .uv_fault(uv_fault), .enable(enable),
      .chop_phase(chop_phase), .flag_n(flag_n), .vds_latched(vds_latched),
      .sh_hold(sh_hold), .sh_zero(sh_zero)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // Behavioural reference: ages and elapsed-cycle counts, updated per edge.
   int m_since;
   bit m_lat;
   int m_age [N];
   bit m_sr [N];
   bit m_rcok [N];
   int m_en;
   bit e_flag = 1'b1;
   bit e_lat  = 1'b0;
   bit e_hold = 1'b0;
   bit e_zero = 1'b0;

   always @(posedge clk) begin : model
      bit det;
      bit clr;
      bit armed;
      if (!rst_n) begin
         m_since = 100000;
         m_lat   = 1'b0;
         for (int i = 0; i < N; i++) begin
            m_age[i] = 0; m_sr[i] = 1'b0; m_rcok[i] = 1'b0;
         end
         m_en = 0;
         e_flag = 1'b1; e_lat = 1'b0; e_hold = 1'b0; e_zero = 1'b0;
      end else begin
         det = 1'b0;
         for (int i = 0; i < N; i++) begin
            armed = sw_on[i] && (m_age[i] >= 1) &&
                    (m_sr[i] ? (m_age[i] >= S + 1) : m_rcok[i]);
            if (armed && vds_trip[i]) det = 1'b1;
         end
         clr   = standby || uv_fault;
         m_lat = clr ? 1'b0 : (m_lat || det);
         if (oc_trip) m_since = 0;
         else if (m_since < 100000) m_since++;
         for (int i = 0; i < N; i++) begin
            if (sw_on[i]) begin
               if (m_age[i] == 0) begin
                  m_sr[i] = sr_offtime; m_rcok[i] = 1'b0;
               end else if (rc_blank_done[i]) begin
                  m_rcok[i] = 1'b1;
               end
               if (m_age[i] < 100000) m_age[i]++;
            end else begin
               m_age[i] = 0; m_rcok[i] = 1'b0;
            end
         end
         if (enable) m_en = 0;
         else if (m_en < AZ) m_en++;
         e_lat  = m_lat;
         e_flag = !((m_since <= H) || m_lat);
         e_zero = m_lat || (m_en == AZ);
         e_hold = !e_zero && ((chop_phase == 2'd1) || (chop_phase == 2'd2 && !enable));
      end
   end

   task automatic check(input string what, input logic act, input bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %b expected %b", what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check("flag_n R1 R2 R3", flag_n, e_flag);
         check("vds_latched R3 R4 R5 R6 R7", vds_latched, e_lat);
         check("sh_hold R8 R10", sh_hold, e_hold);
         check("sh_zero R9 R10", sh_zero, e_zero);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > GUARD && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, GUARD);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_latch();
      standby = 1'b1; tick(1); standby = 1'b0; tick(2);
   endtask

   initial begin
      // Reset state
      tick(3); rst_n = 1'b1; tick(3);

      // R1: single overcurrent pulse and the exact release cycle
      oc_trip = 1'b1; tick(1); oc_trip = 1'b0; tick(H + 6);

      // R2: retriggered trips keep the flag low
      for (int k = 0; k < 4; k++) begin
         oc_trip = 1'b1; tick(1); oc_trip = 1'b0; tick(12);
      end
      tick(H + 5);

      // R5: trips with every switch off
      vds_trip = '1; tick(8); vds_trip = '0;

      // R6: commanded turn-on, trip masked until RC expiry
      vds_trip[0] = 1'b1; sw_on[0] = 1'b1; tick(7);
      rc_blank_done[0] = 1'b1; tick(4);
      vds_trip = '0; rc_blank_done = '0; tick(3);
      // R10: hold request while latched stays suppressed
      chop_phase = 2'd1; tick(3);

      // R4: standby clears; clear wins over a live trip
      clear_latch();
      vds_trip[0] = 1'b1; uv_fault = 1'b1; tick(3);
      uv_fault = 1'b0; tick(3);
      vds_trip = '0; clear_latch();
      sw_on = '0; chop_phase = 2'd0; tick(3);

      // R7: rectification turn-on, fixed window, trip held high
      sr_offtime = 1'b1; sw_on[1] = 1'b1; vds_trip[1] = 1'b1; tick(1);
      sr_offtime = 1'b0; rc_blank_done[1] = 1'b1; tick(S + 3);
      vds_trip = '0; rc_blank_done = '0; clear_latch(); sw_on = '0; tick(2);

      // R7: pulse in last masked cycle, then in the armed region
      sr_offtime = 1'b1; sw_on[2] = 1'b1; tick(1); sr_offtime = 1'b0;
      tick(S - 1); vds_trip[2] = 1'b1; tick(1); vds_trip[2] = 1'b0; tick(3);
      vds_trip[2] = 1'b1; tick(1); vds_trip[2] = 1'b0; tick(2);
      clear_latch(); sw_on = '0; tick(2);

      // R6: expiry in the turn-on cycle is ignored
      sw_on[3] = 1'b1; rc_blank_done[3] = 1'b1; tick(1);
      rc_blank_done[3] = 1'b0; vds_trip[3] = 1'b1; tick(4);
      rc_blank_done[3] = 1'b1; tick(2);
      vds_trip = '0; rc_blank_done = '0; clear_latch(); sw_on = '0; tick(2);

      // R8: every phase with enable high and low
      for (int p = 0; p < 4; p++) begin
         chop_phase = 2'(p); enable = 1'b1; tick(3);
         enable = 1'b0; tick(3);
      end
      enable = 1'b1; chop_phase = 2'd0; tick(3);

      // R9: enable-low timeout and recovery
      chop_phase = 2'd2; enable = 1'b0; tick(AZ + 5);
      enable = 1'b1; tick(4); chop_phase = 2'd0;

      // Concurrency: overcurrent and latch in the same cycle
      sw_on[0] = 1'b1; rc_blank_done[0] = 1'b1; tick(3);
      vds_trip[0] = 1'b1; oc_trip = 1'b1; tick(1);
      oc_trip = 1'b0; vds_trip = '0; tick(H + 5);
      clear_latch(); sw_on = '0; rc_blank_done = '0; tick(3);

      // Concurrency: timeout expiry during a mixed-decay hold
      chop_phase = 2'd1; enable = 1'b0; tick(AZ + 3);
      enable = 1'b1; tick(3); chop_phase = 2'd0; tick(3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule